// File: doc/BRIEF.md
# Pad Boundary Scan Register

A boundary scan data register for a row of bidirectional digital pads plus one input-only reset pad. It sits between the test data input and output of a test access port. The block receives decoded TAP state strobes for capture, shift and update, and a 2-bit instruction code. From these it samples pad-side and core-side signals into a serial chain and shifts them out while new data shifts in. It keeps the preloaded values in a parallel update stage.

Depending on the instruction, the pads and core see their normal signals, or the update stage drives them. Under external test the update stage drives the pads. Under internal test it drives the core inputs. The number of pads and the position of the reset cell in the chain are parameters. The chain holds `3*NUM_PADS + 1` cells. The TAP controller and the instruction register are outside this block.

Top module: `bscan_pad_chain`

## Requirements
- R1: While `trst_n` is low, the shift stage and the update stage are cleared and `tdo` is 0. The clear takes effect without waiting for a clock edge, so a following external test with no update drives 0 onto the pads.
- R2: When the instruction code is not 2'b00 and `capture_dr` is high, a rising `tck` edge loads the chain. Each input cell takes `pad_in`, each output cell takes `core_out`, each enable cell takes `core_oe`, and the reset cell takes `rst_pad_in`.
- R3: The cell order from the `tdi` end to the `tdo` end runs from pad 0 to pad NUM_PADS-1. Each pad has three consecutive cells in the order input, output, output enable. A single reset cell sits just before pad RST_AFTER, or at the `tdo` end when RST_AFTER equals NUM_PADS.
- R4: When the instruction code is not 2'b00 and `shift_dr` is high, but `capture_dr` is low, each rising `tck` edge moves every cell one place toward `tdo`, and the first cell takes `tdi`.
- R5: `tdo` shows the last cell of the chain and changes only on the falling edge of `tck`.
- R6: The update stage copies the whole chain only on a rising `tck` edge with `update_dr` high and the instruction code not 2'b00. It keeps its value through later capture and shift activity.
- R7: With instruction code 2'b10 (external test), `pad_out[k]` and `pad_oe[k]` come from the update-stage output cell and enable cell of pad k. `core_in` still follows `pad_in`.
- R8: With instruction code 2'b11 (internal test), `core_in[k]` comes from the update-stage input cell of pad k, and `core_rst_in` comes from the update-stage reset cell. `pad_out` and `pad_oe` still follow the core.
- R9: With instruction code 2'b01 (sample/preload) or 2'b00 (other), `pad_out`, `pad_oe`, `core_in` and `core_rst_in` equal `core_out`, `core_oe`, `pad_in` and `rst_pad_in`.
- R10: With instruction code 2'b00, the capture, shift and update strobes leave both the chain and the update stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous TAP reset, active low |
| capture_dr | input | 1 | TAP is in the capture state of the data path |
| shift_dr | input | 1 | TAP is in the shift state of the data path |
| update_dr | input | 1 | TAP is in the update state of the data path |
| instr | input | 2 | 00 other, 01 sample/preload, 10 external test, 11 internal test |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the chain, changes on the falling edge |
| pad_in | input | NUM_PADS | Values arriving from the pads |
| core_out | input | NUM_PADS | Output values from the core |
| core_oe | input | NUM_PADS | Output enables from the core |
| rst_pad_in | input | 1 | Value at the reset pad |
| pad_out | output | NUM_PADS | Output values driven to the pads |
| pad_oe | output | NUM_PADS | Output enables driven to the pads |
| core_in | output | NUM_PADS | Input values delivered to the core |
| core_rst_in | output | 1 | Reset pad value delivered to the core |

## Verification
The bench captures a sparse pattern and watches which shift brings the reset-pad bit to `tdo`. A chain with the reset cell misplaced, or with the cells of a pad swapped, shows that bit one shift early or late. It preloads through sample/preload, updates, and then keeps capturing and shifting under external test. An update stage that tracks the chain would change the pad outputs in the middle of a test. Strobes under the "other" code are checked to leave both the chain and the preloaded pad values alone. A bench sample taken just after each rising edge catches a `tdo` that moves on the wrong edge. A reset asserted mid-run checks that the external-test outputs fall back to zero.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        BS_OTHER  = 2'b00,
        BS_SAMPLE = 2'b01,
        BS_EXTEST = 2'b10,
        BS_INTEST = 2'b11
    } bscan_instr_e;

    localparam int CELLS_PER_PAD = 3;
    localparam int OFS_IN        = 0;
    localparam int OFS_OUT       = 1;
    localparam int OFS_OE        = 2;

    // First cell of pad k; the reset cell shifts pads at or after rst_after by one.
    function automatic int pad_base(input int k, input int rst_after);
        return CELLS_PER_PAD * k + ((k >= rst_after) ? 1 : 0);
    endfunction

    function automatic int rst_cell(input int rst_after);
        return CELLS_PER_PAD * rst_after;
    endfunction

endpackage

// File: rtl/bscan_shift_stage.sv
module bscan_shift_stage #(
    parameter int LEN = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_en,
    input  logic           shift_en,
    input  logic [LEN-1:0] cap_vec,
    input  logic           tdi,
    output logic [LEN-1:0] sr_q
);

    typedef struct packed {
        logic [LEN-1:0] sr;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            st_d.sr = cap_vec;
        end else if (shift_en) begin
            st_d.sr = {st_q.sr[LEN-2:0], tdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_q = st_q.sr;

    p_capture_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (sr_q == $past(cap_vec)));

    p_shift_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !cap_en) |=>
            (sr_q[0] == $past(tdi) && sr_q[LEN-1:1] == $past(sr_q[LEN-2:0])));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !cap_en) |=> $stable(sr_q));

endmodule

// File: rtl/bscan_update_stage.sv
module bscan_update_stage #(
    parameter int LEN = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN-1:0] sr_in,
    output logic [LEN-1:0] upd_q
);

    typedef struct packed {
        logic [LEN-1:0] upd;
    } up_state_t;

    up_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.upd = sr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd_q = st_q.upd;

    p_update_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (upd_q == $past(sr_in)));

    p_update_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(upd_q));

endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
    import bscan_pkg::*;
#(
    parameter int NUM_PADS  = 4,
    parameter int RST_AFTER = 2,
    parameter int LEN       = CELLS_PER_PAD * NUM_PADS + 1
) (
    input  logic [1:0]          instr,
    input  logic [LEN-1:0]      upd,
    input  logic [NUM_PADS-1:0] core_out,
    input  logic [NUM_PADS-1:0] core_oe,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic                rst_pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] core_in,
    output logic                core_rst_in
);

    localparam int RST_IDX = rst_cell(RST_AFTER);

    logic ext_mode;
    logic int_mode;

    assign ext_mode = (instr == BS_EXTEST);
    assign int_mode = (instr == BS_INTEST);

    for (genvar k = 0; k < NUM_PADS; k++) begin : g_pad
        localparam int B = pad_base(k, RST_AFTER);
        assign pad_out[k] = ext_mode ? upd[B + OFS_OUT] : core_out[k];
        assign pad_oe[k]  = ext_mode ? upd[B + OFS_OE]  : core_oe[k];
        assign core_in[k] = int_mode ? upd[B + OFS_IN]  : pad_in[k];
    end

    assign core_rst_in = int_mode ? upd[RST_IDX] : rst_pad_in;

endmodule

// File: rtl/bscan_pad_chain.sv
module bscan_pad_chain
    import bscan_pkg::*;
#(
    parameter int NUM_PADS  = 4,
    parameter int RST_AFTER = 2
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic [1:0]          instr,
    input  logic                tdi,
    output logic                tdo,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic [NUM_PADS-1:0] core_out,
    input  logic [NUM_PADS-1:0] core_oe,
    input  logic                rst_pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] core_in,
    output logic                core_rst_in
);

    localparam int LEN     = CELLS_PER_PAD * NUM_PADS + 1;
    localparam int RST_IDX = rst_cell(RST_AFTER);

    logic           chain_sel;
    logic           cap_en;
    logic           shift_en;
    logic           upd_en;
    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] sr;
    logic [LEN-1:0] upd;

    assign chain_sel = (instr != BS_OTHER);
    assign cap_en    = chain_sel && capture_dr;
    assign shift_en  = chain_sel && shift_dr;
    assign upd_en    = chain_sel && update_dr;

    // Capture vector: three cells per pad plus the reset cell.
    for (genvar k = 0; k < NUM_PADS; k++) begin : g_cap
        localparam int B = pad_base(k, RST_AFTER);
        assign cap_vec[B + OFS_IN]  = pad_in[k];
        assign cap_vec[B + OFS_OUT] = core_out[k];
        assign cap_vec[B + OFS_OE]  = core_oe[k];
    end
    assign cap_vec[RST_IDX] = rst_pad_in;

    bscan_shift_stage #(.LEN(LEN)) u_shift (
        .clk      (tck),
        .rst_n    (trst_n),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .cap_vec  (cap_vec),
        .tdi      (tdi),
        .sr_q     (sr)
    );

    bscan_update_stage #(.LEN(LEN)) u_update (
        .clk   (tck),
        .rst_n (trst_n),
        .load  (upd_en),
        .sr_in (sr),
        .upd_q (upd)
    );

    bscan_pad_mux #(
        .NUM_PADS  (NUM_PADS),
        .RST_AFTER (RST_AFTER),
        .LEN       (LEN)
    ) u_mux (
        .instr       (instr),
        .upd         (upd),
        .core_out    (core_out),
        .core_oe     (core_oe),
        .pad_in      (pad_in),
        .rst_pad_in  (rst_pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .core_in     (core_in),
        .core_rst_in (core_rst_in)
    );

    // Serial output retimed to the falling edge.
    logic tdo_d, tdo_q;

    always_comb begin
        tdo_d = sr[LEN-1];
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
        end else begin
            tdo_q <= tdo_d;
        end
    end

    assign tdo = tdo_q;

    p_tdo_follow_r5: assert property (@(posedge tck) disable iff (!trst_n)
        tdo == sr[LEN-1]);

    p_pad_pass_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (instr != BS_EXTEST) |-> (pad_out == core_out && pad_oe == core_oe));

    p_core_pass_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (instr != BS_INTEST) |-> (core_in == pad_in && core_rst_in == rst_pad_in));

    p_extest_stable_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (instr == BS_EXTEST && $past(instr) == BS_EXTEST && !$past(upd_en))
            |-> ($stable(pad_out) && $stable(pad_oe)));

endmodule

// File: tb/bscan_pad_chain_tb.sv
module bscan_pad_chain_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int RA         = 2;
    localparam int L          = 3 * N + 1;

    logic         tck = 1'b0;
    logic         trst_n;
    logic         capture_dr, shift_dr, update_dr;
    logic [1:0]   instr;
    logic         tdi;
    logic         tdo;
    logic [N-1:0] pad_in, core_out, core_oe;
    logic         rst_pad_in;
    logic [N-1:0] pad_out, pad_oe, core_in;
    logic         core_rst_in;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model: bit 0 is the tdi end, bit L-1 the tdo end.
    logic [L-1:0] m_sr, m_up;
    int in_idx[N];
    int out_idx[N];
    int oe_idx[N];
    int rst_idx;

    bscan_pad_chain #(.NUM_PADS(N), .RST_AFTER(RA)) dut_i (
        .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .instr(instr), .tdi(tdi), .tdo(tdo),
        .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe), .rst_pad_in(rst_pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in), .core_rst_in(core_rst_in)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    task automatic build_map();
        int c = 0;
        for (int k = 0; k < N; k++) begin
            if (k == RA) begin rst_idx = c; c++; end
            in_idx[k] = c; out_idx[k] = c + 1; oe_idx[k] = c + 2;
            c += 3;
        end
        if (RA == N) rst_idx = c;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [L-1:0] captured();
        logic [L-1:0] v = '0;
        for (int k = 0; k < N; k++) begin
            v[in_idx[k]]  = pad_in[k];
            v[out_idx[k]] = core_out[k];
            v[oe_idx[k]]  = core_oe[k];
        end
        v[rst_idx] = rst_pad_in;
        return v;
    endfunction

    function automatic logic [N-1:0] exp_pad_out();
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = (instr == 2'b10) ? m_up[out_idx[k]] : core_out[k];
        return v;
    endfunction

    function automatic logic [N-1:0] exp_pad_oe();
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = (instr == 2'b10) ? m_up[oe_idx[k]] : core_oe[k];
        return v;
    endfunction

    function automatic logic [N-1:0] exp_core_in();
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = (instr == 2'b11) ? m_up[in_idx[k]] : pad_in[k];
        return v;
    endfunction

    task automatic check_outputs();
        string t_pad;
        string t_core;
        t_pad  = (instr == 2'b10) ? "R7" : "R9";
        t_core = (instr == 2'b11) ? "R8" : "R9";
        chk("R4", "tdo", 32'(tdo), 32'(m_sr[L-1]));
        chk(t_pad, "pad_out", 32'(pad_out), 32'(exp_pad_out()));
        chk(t_pad, "pad_oe", 32'(pad_oe), 32'(exp_pad_oe()));
        chk(t_core, "core_in", 32'(core_in), 32'(exp_core_in()));
        chk(t_core, "core_rst_in", 32'(core_rst_in),
            32'((instr == 2'b11) ? m_up[rst_idx] : rst_pad_in));
    endtask

    // Called just after a falling edge; returns just after the next falling edge.
    task automatic step(input logic c, input logic s, input logic u);
        logic old_last;
        logic sel;
        logic [L-1:0] nsr;
        capture_dr = c; shift_dr = s; update_dr = u;
        old_last = m_sr[L-1];
        @(posedge tck); #1;
        chk("R5", "tdo after rising edge", 32'(tdo), 32'(old_last));
        sel = (instr != 2'b00);
        nsr = m_sr;
        if (sel && c) nsr = captured();
        else if (sel && s) nsr = {m_sr[L-2:0], tdi};
        if (sel && u) m_up = m_sr;
        m_sr = nsr;
        @(negedge tck); #1;
        capture_dr = 0; shift_dr = 0; update_dr = 0;
        check_outputs();
    endtask

    task automatic do_reset();
        trst_n = 1'b0;
        #2;
        m_sr = '0; m_up = '0;
        chk("R1", "tdo in reset", 32'(tdo), 32'h0);
        @(negedge tck); #1;
        trst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] saved_out, saved_oe;
        void'($urandom(32'h5eed_b5c4));
        build_map();
        trst_n = 1'b0; capture_dr = 0; shift_dr = 0; update_dr = 0;
        instr = 2'b00; tdi = 0; pad_in = 4'b1010; core_out = 4'b0110; core_oe = 4'b0011;
        rst_pad_in = 1'b1;
        m_sr = '0; m_up = '0;
        @(negedge tck); #1;
        do_reset();

        // R1 / R9: pass-through out of reset
        check_outputs();
        instr = 2'b10; #1;
        chk("R1", "pad_out after reset in extest", 32'(pad_out), 32'h0);
        instr = 2'b00;

        // R2 / R3: capture a sparse pattern and walk it out
        instr = 2'b01; pad_in = '0; core_out = '0; core_oe = 4'b1000; rst_pad_in = 1'b1;
        step(1, 0, 0);
        chk("R3", "last cell is enable of last pad", 32'(tdo), 32'h1);
        step(0, 1, 0);
        chk("R3", "second-to-last cell is output of last pad", 32'(tdo), 32'h0);
        for (int j = 1; j < 3 * (N - RA); j++) step(0, 1, 0);
        chk("R3", "reset cell position", 32'(tdo), 32'h1);
        step(0, 1, 0);
        chk("R2", "enable cell of pad before reset cell", 32'(tdo), 32'h0);

        // R6 / R7: preload, update, then external test with ongoing activity
        for (int j = 0; j < L; j++) begin tdi = 1'($urandom); step(0, 1, 0); end
        step(0, 0, 1);
        instr = 2'b10; #1;
        check_outputs();
        saved_out = pad_out; saved_oe = pad_oe;
        core_out = ~core_out; core_oe = ~core_oe;
        step(1, 0, 0);
        for (int j = 0; j < 5; j++) begin tdi = 1'($urandom); step(0, 1, 0); end
        chk("R6", "pad_out held through capture/shift", 32'(pad_out), 32'(saved_out));
        chk("R6", "pad_oe held through capture/shift", 32'(pad_oe), 32'(saved_oe));

        // R10: strobes under the other code are ignored
        instr = 2'b00;
        tdi = 1'b1;
        for (int j = 0; j < 4; j++) step(0, 1, 0);
        step(1, 0, 0);
        step(0, 0, 1);
        instr = 2'b10; #1;
        chk("R10", "pad_out after ignored update", 32'(pad_out), 32'(saved_out));
        chk("R10", "pad_oe after ignored update", 32'(pad_oe), 32'(saved_oe));

        // R8: internal test
        instr = 2'b01;
        for (int j = 0; j < L; j++) begin tdi = 1'($urandom); step(0, 1, 0); end
        step(0, 0, 1);
        instr = 2'b11; pad_in = ~pad_in; rst_pad_in = ~rst_pad_in; #1;
        check_outputs();

        // R1: reset in mid-run clears update stage
        do_reset();
        instr = 2'b10; #1;
        chk("R1", "pad_oe after mid-run reset", 32'(pad_oe), 32'h0);
        check_outputs();

        // Random traffic
        for (int i = 0; i < 500; i++) begin
            int st;
            instr = 2'($urandom);
            tdi = 1'($urandom);
            pad_in = N'($urandom); core_out = N'($urandom); core_oe = N'($urandom);
            rst_pad_in = 1'($urandom);
            st = int'($urandom % 4);
            if (($urandom % 100) == 0) do_reset();
            step(st == 1, st == 2, st == 3);
        end

        finish_run();
    end

endmodule